// File: doc/BRIEF.md
# Retriggerable one-shot pulse generator

This block is a clocked monostable. Two asynchronous trigger inputs are synchronized to the clock. A qualified edge on either of them starts an output pulse whose length is a whole number of clock cycles, taken from the `width_in` bus at the moment of the trigger. One trigger input fires on its falling edge and the other on its rising edge. Each edge is qualified by the level of the other input, so either input can act as an enable for the other.

A qualified edge that arrives while a pulse is running restarts the count. The pulse therefore ends a full width after the last accepted edge, and steady retriggering can hold the output high for as long as needed. Edges that follow the previous accepted edge too closely are discarded. The active-low `clear_n` input ends a running pulse at once and blocks triggering while it is low. Releasing it never starts a pulse.

The block comes out of the synchronous system reset idle. It does not fire on the levels its inputs hold at that moment.

Top module: `mono_oneshot`

## Requirements
- R1: After `rst` is applied, `pulse_q` is 0 and `pulse_qn` is 1.
- R2: A falling edge on `trig_fall_in` starts a pulse when `trig_rise_in` is high and `clear_n` is high.
- R3: While `clear_n` is 0, `pulse_q` is 0 and `pulse_qn` is 1 within the same cycle, and no edge starts or extends a pulse. After `clear_n` returns high, a qualified edge starts a fresh pulse of full width.
- R4: A rising edge on `trig_rise_in` starts a pulse when `trig_fall_in` is low and `clear_n` is high.
- R5: No pulse starts from a falling edge on `trig_fall_in` while `trig_rise_in` is low. No pulse starts from a rising edge on `trig_rise_in` while `trig_fall_in` is high. No pulse starts when `clear_n` rises, whatever the trigger levels are.
- R6: While a pulse runs, a qualified edge is accepted only if it comes at least RETRIG_GAP clock cycles after the previous accepted edge. Closer edges have no effect on the pulse.
- R7: An accepted edge during a pulse reloads the count, so `pulse_q` falls `width_in` cycles after the last accepted edge.
- R8: A change on `trig_fall_in` or `trig_rise_in` that is not a qualified edge neither shortens nor ends a running pulse.
- R9: A trigger input that changes between clock edges raises `pulse_q` after the third rising clock edge. `pulse_q` then stays high for exactly `width_in` cycles, and a `width_in` of 0 gives 1 cycle.
- R10: Input levels present when `rst` is released never start a pulse. This includes `trig_fall_in` low with `trig_rise_in` high.
- R11: `pulse_qn` is always the complement of `pulse_q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous system reset, active high |
| clear_n | input | 1 | Active-low pulse clear and trigger inhibit |
| trig_fall_in | input | 1 | Trigger that fires on its falling edge, asynchronous |
| trig_rise_in | input | 1 | Trigger that fires on its rising edge, asynchronous |
| width_in | input | WIDTH_BITS | Pulse length in clock cycles, sampled when a trigger is accepted |
| pulse_q | output | 1 | Pulse output, active high |
| pulse_qn | output | 1 | Complement of `pulse_q` |

## Verification
Each trigger input is fired alone with several widths, among them 0 and 1. This separates the two edge polarities and pins down both the latency and the length. Each is also fired with its qualifying level held the wrong way, which shows that the gating looks at the other input and not at the input's own history. Pairs of edges placed just under and exactly at the retrigger spacing separate a retrigger that is dropped from one that is accepted. Sequences with a clear in the middle of a pulse, and with trigger levels already set when the clear or the system reset is released, show that an edge and a level are treated differently.

// File: rtl/mono_pkg.sv
package mono_pkg;

    // Depth of the input synchronizer chain.
    localparam int unsigned SYNC_DEPTH = 2;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_ACTIVE = 1'b1
    } pulse_state_t;

    // Qualified trigger events seen in one cycle.
    typedef struct packed {
        logic fall_a;
        logic rise_b;
    } trig_evt_t;

    // A zero width is stretched to a single cycle.
    function automatic logic [31:0] eff_width(input logic [31:0] w);
        return (w == 32'd0) ? 32'd1 : w;
    endfunction

endpackage

// File: rtl/mono_sync.sv
module mono_sync #(
    parameter int unsigned NBITS  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NBITS-1:0] din,
    output logic [NBITS-1:0] dout
);
    for (genvar i = 0; i < NBITS; i++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= '0;
            else     chain <= {chain[STAGES-2:0], din[i]};
        end
        assign dout[i] = chain[STAGES-1];
    end
endmodule

// File: rtl/mono_edge.sv
module mono_edge
    import mono_pkg::*;
#(
    parameter int unsigned ARM_LEN = 3
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      a_s,
    input  logic      b_s,
    input  logic      clear_n,
    output trig_evt_t evt
);
    logic               a_prev;
    logic               b_prev;
    logic [ARM_LEN-1:0] arm;
    logic               armed;

    // Edges count only once the synchronizer and the history flop hold real samples.
    always_ff @(posedge clk) begin
        if (rst) begin
            a_prev <= 1'b0;
            b_prev <= 1'b0;
            arm    <= '0;
        end else begin
            a_prev <= a_s;
            b_prev <= b_s;
            arm    <= {arm[ARM_LEN-2:0], 1'b1};
        end
    end

    assign armed = arm[ARM_LEN-1];

    always_comb begin
        evt.fall_a = armed & clear_n & a_prev & ~a_s & b_s;
        evt.rise_b = armed & clear_n & ~b_prev & b_s & ~a_s;
    end
endmodule

// File: rtl/mono_timer.sv
module mono_timer
    import mono_pkg::*;
#(
    parameter int unsigned WB  = 16,
    parameter int unsigned GAP = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear_n,
    input  logic          fire,
    input  logic [WB-1:0] width_in,
    output pulse_state_t  state,
    output logic          accept
);
    localparam int unsigned GW = $clog2(GAP + 1);

    logic [WB-1:0] remaining;
    logic [GW-1:0] since;
    logic [WB-1:0] w_eff;

    assign w_eff  = WB'(eff_width(32'(width_in)));
    assign accept = fire & ((state == ST_IDLE) | (since >= GW'(GAP)));

    always_ff @(posedge clk) begin
        if (rst || !clear_n) begin
            state     <= ST_IDLE;
            remaining <= '0;
            since     <= GW'(GAP);
        end else if (accept) begin
            state     <= ST_ACTIVE;
            remaining <= w_eff;
            since     <= GW'(1);
        end else begin
            if (since < GW'(GAP)) since <= since + GW'(1);
            if (state == ST_ACTIVE) begin
                if (remaining <= WB'(1)) begin
                    state     <= ST_IDLE;
                    remaining <= '0;
                end else begin
                    remaining <= remaining - WB'(1);
                end
            end
        end
    end
endmodule

// File: rtl/mono_oneshot.sv
module mono_oneshot
    import mono_pkg::*;
#(
    parameter int unsigned WIDTH_BITS = 16,
    parameter int unsigned RETRIG_GAP = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  clear_n,
    input  logic                  trig_fall_in,
    input  logic                  trig_rise_in,
    input  logic [WIDTH_BITS-1:0] width_in,
    output logic                  pulse_q,
    output logic                  pulse_qn
);
    localparam int unsigned ARM_LEN = SYNC_DEPTH + 1;

    logic [1:0]   sync_out;
    trig_evt_t    evt;
    logic         trig_fire;
    logic         trig_accept;
    pulse_state_t state;

    mono_sync #(.NBITS(2), .STAGES(SYNC_DEPTH)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  ({trig_rise_in, trig_fall_in}),
        .dout (sync_out)
    );

    mono_edge #(.ARM_LEN(ARM_LEN)) u_edge (
        .clk     (clk),
        .rst     (rst),
        .a_s     (sync_out[0]),
        .b_s     (sync_out[1]),
        .clear_n (clear_n),
        .evt     (evt)
    );

    assign trig_fire = evt.fall_a | evt.rise_b;

    mono_timer #(.WB(WIDTH_BITS), .GAP(RETRIG_GAP)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .clear_n  (clear_n),
        .fire     (trig_fire),
        .width_in (width_in),
        .state    (state),
        .accept   (trig_accept)
    );

    // Clear acts on the outputs without waiting for a clock edge.
    assign pulse_q  = (state == ST_ACTIVE) & clear_n;
    assign pulse_qn = ~pulse_q;
endmodule

// File: rtl/mono_oneshot_chk.sv
module mono_oneshot_chk #(
    parameter int unsigned RETRIG_GAP = 2,
    parameter int unsigned ARM_LEN    = 3
) (
    input logic clk,
    input logic rst,
    input logic clear_n,
    input logic pulse_q,
    input logic trig_fire,
    input logic trig_accept
);
    localparam int unsigned CW = $clog2(RETRIG_GAP + 2);

    logic [3:0]    por_cnt;
    logic [CW-1:0] gap_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            por_cnt <= '0;
            gap_cnt <= CW'(RETRIG_GAP);
        end else begin
            if (por_cnt != 4'hF) por_cnt <= por_cnt + 4'd1;
            if (trig_accept)                 gap_cnt <= CW'(1);
            else if (gap_cnt < CW'(RETRIG_GAP)) gap_cnt <= gap_cnt + CW'(1);
        end
    end

    a_r3_clear_ends_pulse: assert property (@(posedge clk) disable iff (rst)
        !clear_n |=> !pulse_q);

    a_r5_rise_needs_trigger: assert property (@(posedge clk) disable iff (rst)
        $rose(pulse_q) |-> $past(trig_fire));

    a_r10_no_fire_after_reset: assert property (@(posedge clk) disable iff (rst)
        trig_fire |-> (por_cnt >= 4'(ARM_LEN)));

    a_r6_retrigger_spacing: assert property (@(posedge clk) disable iff (rst)
        (trig_accept && pulse_q) |-> (gap_cnt >= CW'(RETRIG_GAP)));

    a_r7_accept_starts_pulse: assert property (@(posedge clk) disable iff (rst)
        trig_accept |=> (pulse_q || !clear_n));
endmodule

bind mono_oneshot mono_oneshot_chk #(
    .RETRIG_GAP (RETRIG_GAP),
    .ARM_LEN    (ARM_LEN)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .clear_n     (clear_n),
    .pulse_q     (pulse_q),
    .trig_fire   (trig_fire),
    .trig_accept (trig_accept)
);

// File: tb/mono_oneshot_bench.sv
module mono_oneshot_bench;
    localparam int unsigned WB  = 8;
    localparam int unsigned GAP = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          clear_n = 1'b1;
    logic          a = 1'b1;
    logic          b = 1'b0;
    logic [WB-1:0] width = '0;
    logic          q, qn;
    int            checks = 0;
    int            fails = 0;
    bit            done = 1'b0;

    always #4 clk = ~clk;

    mono_oneshot #(.WIDTH_BITS(WB), .RETRIG_GAP(GAP)) u_mono_oneshot (
        .clk(clk), .rst(rst), .clear_n(clear_n), .trig_fall_in(a),
        .trig_rise_in(b), .width_in(width), .pulse_q(q), .pulse_qn(qn)
    );

    typedef struct packed {
        logic [7:0] w;
        logic       kind;   // 0: fall edge on a, 1: rise edge on b
        logic       other;  // level of the qualifying input
        logic [7:0] exp_len;
    } vec_t;

    // R2 (kind 0, b high), R4 (kind 1, a low), R5 (wrong level -> 0), R9 widths incl. 0
    localparam vec_t VECS [8] = '{
        '{8'd5,  1'b0, 1'b1, 8'd5},
        '{8'd0,  1'b0, 1'b1, 8'd1},
        '{8'd1,  1'b1, 1'b0, 8'd1},
        '{8'd9,  1'b1, 1'b0, 8'd9},
        '{8'd3,  1'b0, 1'b0, 8'd0},
        '{8'd4,  1'b1, 1'b1, 8'd0},
        '{8'd12, 1'b1, 1'b0, 8'd12},
        '{8'd2,  1'b0, 1'b1, 8'd2}
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic measure(input int n, output int highs, output int first, output int bad);
        highs = 0; first = -1; bad = 0;
        for (int i = 1; i <= n; i++) begin
            @(negedge clk);
            if (q) begin
                highs++;
                if (first < 0) first = i;
            end
            if (qn !== ~q) bad++;
        end
    endtask

    initial begin
        int h, f, bd, hl;
        wait_cyc(3);
        rst = 1'b0;
        wait_cyc(5);
        check(q == 1'b0 && qn == 1'b1, "R1 reset state q", int'(q), 0);

        // table walk
        foreach (VECS[k]) begin
            width = VECS[k].w;
            if (VECS[k].kind == 1'b0) b = VECS[k].other; else a = VECS[k].other;
            wait_cyc(4);
            if (VECS[k].kind == 1'b0) a = 1'b0; else b = 1'b1;
            measure(30, h, f, bd);
            check(h == int'(VECS[k].exp_len), "R9 R5 vector length", h, int'(VECS[k].exp_len));
            if (VECS[k].exp_len != 0) check(f == 3, "R9 latency", f, 3);
            check(bd == 0, "R11 complement", bd, 0);
            if (VECS[k].kind == 1'b0) begin a = 1'b1; @(negedge clk); b = 1'b0; end
            else begin b = 1'b0; @(negedge clk); a = 1'b1; end
            wait_cyc(4);
        end

        // R8: non-qualifying changes during a pulse
        width = 8; b = 1'b1; wait_cyc(4); a = 1'b0;
        h = 0;
        for (int i = 1; i <= 30; i++) begin
            @(negedge clk);
            if (q) h++;
            if (i == 1) a = 1'b1;
            if (i == 2) b = 1'b0;
        end
        check(h == 8, "R8 pulse kept full length", h, 8);
        wait_cyc(4);

        // R7: accepted retrigger 4 cycles later extends the pulse
        width = 6; b = 1'b1; wait_cyc(4); a = 1'b0;
        h = 0;
        for (int i = 1; i <= 30; i++) begin
            @(negedge clk);
            if (q) h++;
            if (i == 2) a = 1'b1;
            if (i == 4) a = 1'b0;
        end
        check(h == 10, "R7 retrigger extends", h, 10);
        a = 1'b1; @(negedge clk); b = 1'b0; wait_cyc(4);

        // R6: second edge 2 cycles after the first is dropped
        width = 6; a = 1'b0; wait_cyc(4); b = 1'b1;
        h = 0;
        for (int i = 1; i <= 30; i++) begin
            @(negedge clk);
            if (q) h++;
            if (i == 1) b = 1'b0;
            if (i == 2) b = 1'b1;
        end
        check(h == 6, "R6 close retrigger ignored", h, 6);
        b = 1'b0; wait_cyc(4);

        // R6 boundary: edge exactly GAP cycles later is taken
        b = 1'b1;
        h = 0;
        for (int i = 1; i <= 30; i++) begin
            @(negedge clk);
            if (q) h++;
            if (i == 1) b = 1'b0;
            if (i == 3) b = 1'b1;
        end
        check(h == 9, "R6 retrigger at spacing accepted", h, 9);
        b = 1'b0; @(negedge clk); a = 1'b1; wait_cyc(4);

        // R3: clear mid-pulse, edge during clear, release with levels set
        width = 10; b = 1'b1; wait_cyc(4); a = 1'b0;
        h = 0; hl = 0;
        for (int i = 1; i <= 30; i++) begin
            @(negedge clk);
            if (q) h++;
            if (q && i > 14) hl++;
            if (i == 5) begin
                clear_n = 1'b0;
                #1;
                check(q == 1'b0 && qn == 1'b1, "R3 clear forces outputs", int'(q), 0);
            end
            if (i == 6) a = 1'b1;
            if (i == 8) a = 1'b0;
            if (i == 14) clear_n = 1'b1;
        end
        check(h == 3, "R3 pulse cut by clear", h, 3);
        check(hl == 0, "R5 clear release does not fire", hl, 0);
        a = 1'b1; wait_cyc(4); a = 1'b0;
        measure(30, h, f, bd);
        check(h == 10, "R3 fresh pulse after clear", h, 10);
        a = 1'b1; @(negedge clk); b = 1'b0; wait_cyc(4);

        // R10: levels that would qualify are held through reset release
        rst = 1'b1; @(negedge clk); a = 1'b0; b = 1'b1; wait_cyc(3);
        check(q == 1'b0 && qn == 1'b1, "R1 outputs during reset", int'(q), 0);
        rst = 1'b0;
        measure(15, h, f, bd);
        check(h == 0, "R10 no pulse after reset release", h, 0);
        b = 1'b0; @(negedge clk); a = 1'b1; wait_cyc(4);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule